// File: doc/BRIEF.md
# SRAM Sleep Sequencer

This block controls the low-power state of a synchronous SRAM. An asynchronous sleep request passes through a flop synchronizer. A four-state machine then moves the memory from normal operation into power-down and back. Each transition takes a fixed window of clock cycles. During that window the block drives a core power-down indication and a ready flag. It also masks access requests and reports the ones it throws away. The stored array contents are never touched by the sequencer.

Around a sleep period the block checks the memory's control inputs. If the chip select or either address strobe goes active during the recovery window, a sticky violation flag is set. The same flag is set if the device is still selected when entry begins. The flag stays set until reset. Integration ties the sleep request low when it is unused, which keeps the memory permanently active.

Top module: `sram_sleep_seq`

## Requirements
- R1: After reset, ready is 1, core_pd is 0 and violation is 0.
- R2: The sleep request is synchronized by two flops. Ready falls on the third rising clock edge after sleep_req goes high, not earlier.
- R3: Entry lasts ENTRY_CYCLES (2) cycles in which neither ready nor core_pd is high. Core_pd then rises on the fifth rising edge after the request. Once entry has begun it completes, even if the request is withdrawn.
- R4: While the synchronized request stays high after entry, core_pd stays high. Core_pd is high only in the sleep state.
- R5: After the synchronized request goes low, recovery lasts EXIT_CYCLES (2) cycles with ready and core_pd both low. Ready returns on the fifth rising edge after sleep_req falls.
- R6: acc_grant equals acc_req while ready is high, and is 0 otherwise.
- R7: acc_discard is 1 whenever acc_req is high while ready is low, and 0 otherwise.
- R8: chip_sel, strobe_proc or strobe_ctrl high at a clock edge during recovery sets violation. The same inputs in the sleep state do not set it.
- R9: If chip_sel is high at the edge where the machine leaves the active state for entry, violation is set.
- R10: Violation, once set, stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep_req | input | 1 | Asynchronous sleep request, high requests sleep |
| chip_sel | input | 1 | Combined chip select, high when selected |
| strobe_proc | input | 1 | Processor-side address strobe, high when active |
| strobe_ctrl | input | 1 | Controller-side address strobe, high when active |
| acc_req | input | 1 | Access request from the memory front end |
| acc_grant | output | 1 | Access allowed to proceed |
| acc_discard | output | 1 | Access request invalidated because the block is not ready |
| core_pd | output | 1 | Core power-down indication |
| ready | output | 1 | High only in the active state |
| violation | output | 1 | Sticky select/strobe protocol violation |

## Verification
A wrong state shows up on ready and core_pd at once, because both are decoded directly from the state register. A miscounted window moves the rising edge of core_pd or ready by a whole cycle. The bench therefore samples the exact edge number after each request change. A bad synchronizer depth shifts both edges together. A missed violation case shows up one edge after the offending input, and it must remain visible through to the next reset.

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq #(
  parameter int SYNC_STAGES  = 2,
  parameter int ENTRY_CYCLES = 2,
  parameter int EXIT_CYCLES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_req,
  input  logic chip_sel,
  input  logic strobe_proc,
  input  logic strobe_ctrl,
  input  logic acc_req,
  output logic acc_grant,
  output logic acc_discard,
  output logic core_pd,
  output logic ready,
  output logic violation
);

  localparam int MAXW = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
  localparam int CW   = (MAXW > 1) ? $clog2(MAXW) : 1;
  localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYCLES - 1);
  localparam logic [CW-1:0] EXIT_LAST  = CW'(EXIT_CYCLES - 1);

  typedef enum logic [1:0] {ST_ACTIVE, ST_ENTERING, ST_SLEEP, ST_EXITING} state_t;

  state_t                 st;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;
  logic                   req_s;
  logic                   ctl_busy;

  assign req_s    = sync_q[SYNC_STAGES-1];
  assign ctl_busy = chip_sel | strobe_proc | strobe_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sleep_req};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_ACTIVE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_ACTIVE: begin
          cnt <= '0;
          if (req_s) st <= ST_ENTERING;
        end
        ST_ENTERING: begin
          if (cnt == ENTRY_LAST) begin
            cnt <= '0;
            st  <= ST_SLEEP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SLEEP: begin
          cnt <= '0;
          if (!req_s) st <= ST_EXITING;
        end
        ST_EXITING: begin
          if (cnt == EXIT_LAST) begin
            cnt <= '0;
            st  <= ST_ACTIVE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      violation <= 1'b0;
    else if ((st == ST_EXITING && ctl_busy) || (st == ST_ACTIVE && req_s && chip_sel))
      violation <= 1'b1;
  end

  assign ready       = (st == ST_ACTIVE);
  assign core_pd     = (st == ST_SLEEP);
  assign acc_grant   = acc_req & ready;
  assign acc_discard = acc_req & ~ready;

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation); // R10
  AST_EXIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_EXITING && ctl_busy) |=> violation); // R8
  AST_ENTRY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && req_s && chip_sel) |=> violation); // R9
  AST_PD_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pd) |-> $past(st) == ST_ENTERING); // R3
  AST_READY_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(st) == ST_EXITING); // R5
  AST_ENTRY_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ENTERING) |=> (st == ST_ENTERING || st == ST_SLEEP)); // R3
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP && req_s) |=> core_pd); // R4
  AST_ACTIVE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACTIVE && !req_s) |=> ready); // R2

endmodule

// File: tb/sram_sleep_seq_tb.sv
module sram_sleep_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, chip_sel = 1'b0, strobe_proc = 1'b0, strobe_ctrl = 1'b0, acc_req = 1'b0;
  logic acc_grant, acc_discard, core_pd, ready, violation;
  int applied = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sram_sleep_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
    .strobe_proc(strobe_proc), .strobe_ctrl(strobe_ctrl), .acc_req(acc_req),
    .acc_grant(acc_grant), .acc_discard(acc_discard), .core_pd(core_pd),
    .ready(ready), .violation(violation)
  );

  // inputs [9:5] = sleep_req, chip_sel, strobe_proc, strobe_ctrl, acc_req
  // expected [4:0] = ready, core_pd, acc_grant, acc_discard, violation
  localparam logic [9:0] VEC [14] = '{
    10'b01001_10100,
    10'b10000_10000,
    10'b10001_10100,
    10'b10001_10100,
    10'b10001_00010,
    10'b10000_00000,
    10'b10000_01000,
    10'b00001_01010,
    10'b00000_01000,
    10'b00000_01000,
    10'b00000_00000,
    10'b00000_00000,
    10'b00000_10000,
    10'b00001_10100
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [4:0] exp);
    logic [4:0] act;
    #1;
    act = {ready, core_pd, acc_grant, acc_discard, violation};
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b (ready,pd,grant,discard,viol)", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {sleep_req, chip_sel, strobe_proc, strobe_ctrl, acc_req} = '0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    chk("R1 reset state", 5'b10000);

    for (int i = 0; i < 14; i++) begin
      if (i > 0) step();
      {sleep_req, chip_sel, strobe_proc, strobe_ctrl, acc_req} = VEC[i][9:5];
      chk($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", i), VEC[i][4:0]);
    end

    // R3: entry completes even when the request is withdrawn
    do_reset();
    sleep_req = 1'b1;
    step(); chk("R2 edge 1", 5'b10000);
    step(); chk("R2 edge 2", 5'b10000);
    step(); chk("R2 edge 3 ready low", 5'b00000);
    sleep_req = 1'b0;
    step(); chk("R3 entering after withdrawal", 5'b00000);
    step(); chk("R3 sleep reached anyway", 5'b01000);
    step(); chk("R5 exit begins", 5'b00000);
    step(); step(); chk("R5 ready back", 5'b10000);

    // R8 / R10: strobes in sleep are ignored, in recovery they flag
    do_reset();
    sleep_req = 1'b1;
    repeat (5) step();
    chk("R4 asleep", 5'b01000);
    chip_sel = 1'b1; strobe_proc = 1'b1;
    step(); chk("R8 selects in sleep ignored", 5'b01000);
    chip_sel = 1'b0; strobe_proc = 1'b0;
    sleep_req = 1'b0;
    step(); step(); step();
    chk("R5 recovery state", 5'b00000);
    strobe_ctrl = 1'b1;
    step(); chk("R8 strobe during recovery", 5'b00001);
    strobe_ctrl = 1'b0;
    step(); chk("R10 flag held at ready", 5'b10001);
    repeat (3) step();
    chk("R10 flag still held", 5'b10001);
    do_reset();
    chk("R1 R10 reset clears flag", 5'b10000);

    // R9: selected when entry begins
    chip_sel = 1'b1; sleep_req = 1'b1;
    step(); step(); chk("R9 before entry", 5'b10000);
    step(); chk("R9 selected at entry", 5'b00001);
    chip_sel = 1'b0;
    step(); step(); chk("R9 flag held into sleep", 5'b01001);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule